// File: doc/BRIEF.md
# Microframe Interrupt Threshold Moderator

This block limits how often a USB host controller raises its interrupt line. It keeps a register of pending event bits, which event inputs set and a write-one-to-clear input clears, and a matching enable mask selects which of them may interrupt. A pending enabled event does not interrupt at once. It is held until the next threshold boundary, and the boundaries fall every N microframes, where N is the active threshold.

The threshold arrives as an 8-bit code from the command register. The legal codes are 1, 2, 4, 8, 16, 32 and 64 microframes. Code 8 is 1 ms, 16 is 2 ms, 32 is 4 ms and 64 is 8 ms, and the reset value is 8. A new code is adopted only while the controller is halted and only when it is legal. Any other change leaves the previous threshold in force and raises an error flag. The microframe counter is held at zero while the controller is halted, so the first boundary after start comes one full interval later.

Top module: `uframe_irq_moderator`

## Requirements
- R1: After reset, `thr_active` is 8, while `irq`, `thr_err` and `status` are all 0.
- R2: While `halted` is 1, a legal code (1, 2, 4, 8, 16, 32 or 64) on `thr_code` becomes `thr_active` one clock later, and `thr_err` is 0 from then on.
- R3: A code that is 0, not a power of two, or above 64 is never adopted. `thr_active` keeps its previous value, and `thr_err` reads 1 one clock after such a code appears.
- R4: While `halted` is 0, any `thr_code` that differs from `thr_active` (legal or not) leaves `thr_active` unchanged and sets `thr_err`.
- R5: While running, a boundary occurs on every `thr_active`-th registered `uframe_tick` pulse, and the counter then restarts from zero.
- R6: The counter is held at zero while `halted` is 1. The first boundary after `halted` falls is the `thr_active`-th tick after that.
- R7: `irq` rises only on the clock edge that registers a boundary tick, and only if some bit of `status & enable` is 1 at that edge. It never rises while halted.
- R8: Once `irq` is asserted, it stays 1 until every enabled pending bit has been cleared. It falls on the same edge that clears the last one.
- R9: Bit i of `evt_set` sets `status[i]`. A 1 on bit i of `evt_clr` clears it, and set wins over clear in the same cycle. A pending bit whose enable is 0 never asserts `irq`.
- R10: `thr_err` returns to 0 one clock after `thr_code` equals `thr_active` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halted | input | 1 | 1 while the host controller is in the halted state |
| uframe_tick | input | 1 | One-clock pulse per microframe |
| thr_code | input | 8 | Requested interrupt threshold code |
| enable | input | NSRC | Interrupt enable mask, one bit per event |
| evt_set | input | NSRC | Event pulses that set pending bits |
| evt_clr | input | NSRC | Write-one-to-clear for the pending bits |
| status | output | NSRC | Pending event bits |
| irq | output | 1 | Moderated interrupt request |
| thr_active | output | 8 | Threshold currently in force |
| thr_err | output | 1 | Requested code was rejected |

## Verification
The assertions assume the following about the inputs. `uframe_tick` is a single-clock pulse. `halted` describes the controller state, not a glitch. The threshold register can therefore only move at edges where `halted` is sampled high. The bench drives every input on the falling clock edge and spaces tick pulses two clocks apart. It changes codes while halted, except in the dedicated running-change test. It sweeps all 256 codes and runs every legal threshold through two full intervals.

// File: rtl/uframe_irq_pkg.sv
package uframe_irq_pkg;
  localparam int unsigned THR_W   = 8;
  localparam int unsigned THR_RST = 8;

  // legal: nonzero power of two not above max_thr
  function automatic logic thr_legal(input logic [THR_W-1:0] code,
                                     input int unsigned max_thr);
    return (code != '0) && (int'(code) <= int'(max_thr)) &&
           ((code & (code - THR_W'(1))) == '0);
  endfunction

  // next counter value extended to threshold width
  function automatic logic [THR_W-1:0] cnt_next(input logic [THR_W-1:0] cnt);
    return cnt + THR_W'(1);
  endfunction
endpackage

// File: rtl/uframe_thr_reg.sv
module uframe_thr_reg
  import uframe_irq_pkg::*;
#(
  parameter int unsigned MAX_THR = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halted,
  input  logic [THR_W-1:0] thr_code,
  output logic [THR_W-1:0] thr_q,
  output logic             err_q
);
  logic differs, legal, adopt, reject;

  assign differs = (thr_code != thr_q);
  assign legal   = thr_legal(thr_code, MAX_THR);
  assign adopt   = differs && halted && legal;
  assign reject  = differs && !(halted && legal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_W'(THR_RST);
      err_q <= 1'b0;
    end else begin
      if (adopt) thr_q <= thr_code;
      err_q <= reject;
    end
  end

  p_thr_always_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    thr_legal(thr_q, MAX_THR));
  p_run_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> $stable(thr_q));
  p_reject_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err_q && $stable(thr_q)));
  p_match_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> !err_q);
endmodule

// File: rtl/uframe_counter.sv
module uframe_counter
  import uframe_irq_pkg::*;
#(
  parameter int unsigned MAX_THR = 64,
  localparam int unsigned CNT_W = $clog2(MAX_THR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halted,
  input  logic             tick,
  input  logic [THR_W-1:0] thr,
  output logic             bnd
);
  logic [CNT_W-1:0] cnt;

  assign bnd = tick && !halted && (cnt_next(THR_W'(cnt)) == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (halted) cnt <= '0;
    else if (tick)   cnt <= bnd ? '0 : cnt + CNT_W'(1);
  end

  p_cnt_below_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    THR_W'(cnt) < thr);
  p_halt_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (cnt == '0));
  p_no_bnd_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !bnd);
endmodule

// File: rtl/uframe_irq_gate.sv
module uframe_irq_gate #(
  parameter int unsigned NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bnd,
  input  logic [NSRC-1:0] enable,
  input  logic [NSRC-1:0] evt_set,
  input  logic [NSRC-1:0] evt_clr,
  output logic [NSRC-1:0] status_q,
  output logic            irq_q
);
  logic [NSRC-1:0] status_nxt;
  logic            pend_nxt;

  assign status_nxt = (status_q & ~evt_clr) | evt_set;
  assign pend_nxt   = |(status_nxt & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      irq_q    <= pend_nxt && (irq_q || bnd);
    end
  end

  p_irq_rise_on_bnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(bnd));
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && pend_nxt) |=> irq_q);
  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_nxt |=> !irq_q);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));
endmodule

// File: rtl/uframe_irq_moderator.sv
module uframe_irq_moderator
  import uframe_irq_pkg::*;
#(
  parameter int unsigned NSRC    = 6,
  parameter int unsigned MAX_THR = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halted,
  input  logic            uframe_tick,
  input  logic [7:0]      thr_code,
  input  logic [NSRC-1:0] enable,
  input  logic [NSRC-1:0] evt_set,
  input  logic [NSRC-1:0] evt_clr,
  output logic [NSRC-1:0] status,
  output logic            irq,
  output logic [7:0]      thr_active,
  output logic            thr_err
);
  logic [THR_W-1:0] thr_q;
  logic             bnd;

  uframe_thr_reg #(.MAX_THR(MAX_THR)) u_thr (
    .clk(clk), .rst_n(rst_n), .halted(halted), .thr_code(thr_code),
    .thr_q(thr_q), .err_q(thr_err)
  );

  uframe_counter #(.MAX_THR(MAX_THR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .halted(halted), .tick(uframe_tick),
    .thr(thr_q), .bnd(bnd)
  );

  uframe_irq_gate #(.NSRC(NSRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .enable(enable),
    .evt_set(evt_set), .evt_clr(evt_clr), .status_q(status), .irq_q(irq)
  );

  assign thr_active = thr_q;

  p_reset_default_r1: assert property (@(posedge clk)
    !rst_n |=> (thr_active == 8'd8 || rst_n));
endmodule

// File: tb/uframe_irq_moderator_tb.sv
module uframe_irq_moderator_tb;
  localparam int NSRC = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            halted = 1'b1;
  logic            uframe_tick = 1'b0;
  logic [7:0]      thr_code = 8'd8;
  logic [NSRC-1:0] enable = '0;
  logic [NSRC-1:0] evt_set = '0;
  logic [NSRC-1:0] evt_clr = '0;
  logic [NSRC-1:0] status;
  logic            irq;
  logic [7:0]      thr_active;
  logic            thr_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uframe_irq_moderator #(.NSRC(NSRC), .MAX_THR(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .halted(halted), .uframe_tick(uframe_tick),
    .thr_code(thr_code), .enable(enable), .evt_set(evt_set), .evt_clr(evt_clr),
    .status(status), .irq(irq), .thr_active(thr_active), .thr_err(thr_err)
  );

  function automatic bit code_ok(input int c);
    for (int k = 0; k < 7; k++) if (c == (1 << k)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    uframe_tick = 1'b1; cyc(1);
    uframe_tick = 1'b0; cyc(1);
  endtask

  task automatic pulse_set(input logic [NSRC-1:0] m);
    evt_set = m; cyc(1); evt_set = '0;
  endtask

  task automatic pulse_clr(input logic [NSRC-1:0] m);
    evt_clr = m; cyc(1); evt_clr = '0;
  endtask

  task automatic ticks_to_irq(output int n);
    n = 0;
    while (!irq && n < 300) begin do_tick(); n++; end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int prev, n;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1", "thr_active", thr_active, 8);
    chk("R1", "irq", irq, 0);
    chk("R1", "thr_err", thr_err, 0);
    chk("R1", "status", status, 0);

    // R3 / R2 sweep of every code while halted
    prev = 8;
    for (int c = 0; c < 256; c++) begin
      thr_code = 8'(c);
      cyc(2);
      if (code_ok(c)) prev = c;
      chk(code_ok(c) ? "R2" : "R3", "thr_active", thr_active, prev);
      chk(code_ok(c) ? "R2" : "R3", "thr_err", thr_err, (c == prev) ? 0 : 1);
    end

    // R5 R6 R7 R8 for every legal threshold
    enable = '1;
    for (int k = 0; k < 7; k++) begin
      int c = 1 << k;
      halted = 1'b1;
      thr_code = 8'(c);
      cyc(2);
      chk("R2", "thr_active legal", thr_active, c);
      pulse_clr('1);
      pulse_set(6'b000001);
      do_tick();
      chk("R7", "irq while halted", irq, 0);
      halted = 1'b0;
      ticks_to_irq(n);
      chk("R6", "ticks to first boundary", n, c);
      pulse_clr(6'b000001);
      chk("R8", "irq after clear", irq, 0);
      pulse_set(6'b000001);
      chk("R7", "irq before boundary", irq, (c == 1) ? 0 : 0);
      ticks_to_irq(n);
      chk("R5", "ticks between boundaries", n, c);
      cyc(3);
      chk("R8", "irq held", irq, 1);
    end

    // R4 / R10 changes while running
    halted = 1'b1;
    thr_code = 8'd8;
    cyc(2);
    halted = 1'b0;
    cyc(1);
    thr_code = 8'd4;
    cyc(2);
    chk("R4", "thr_active legal run change", thr_active, 8);
    chk("R4", "thr_err legal run change", thr_err, 1);
    thr_code = 8'd8;
    cyc(2);
    chk("R10", "thr_err restored", thr_err, 0);
    thr_code = 8'd3;
    cyc(2);
    chk("R4", "thr_active illegal run change", thr_active, 8);
    chk("R4", "thr_err illegal run change", thr_err, 1);
    thr_code = 8'd8;
    cyc(2);
    chk("R10", "thr_err restored again", thr_err, 0);

    // R9 status set/clear and masking
    pulse_clr('1);
    enable = 6'b000001;
    pulse_set(6'b000010);
    chk("R9", "status set", status, 2);
    for (int i = 0; i < 10; i++) do_tick();
    chk("R9", "masked bit no irq", irq, 0);
    evt_set = 6'b000010; evt_clr = 6'b000010; cyc(1);
    evt_set = '0; evt_clr = '0;
    chk("R9", "set wins over clear", status, 2);
    pulse_clr(6'b000010);
    chk("R9", "w1c clears", status, 0);

    // R8 with two enabled pending bits
    enable = '1;
    pulse_set(6'b000101);
    ticks_to_irq(n);
    chk("R5", "boundary within interval", (n >= 1 && n <= 8) ? 1 : 0, 1);
    pulse_clr(6'b000001);
    chk("R8", "irq with one bit left", irq, 1);
    pulse_clr(6'b000100);
    chk("R8", "irq after last clear", irq, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule